// File: doc/BRIEF.md
# Predicated Vector Pack/Unpack Sequencer

This block walks a vector of up to 16 elements, one element per clock, and moves data between two register groups of different shape. On one side every element is a single 32-bit word. On the other side every element is a group of SUBVL narrow slots, each holding one byte. The two sides step at different rates: the word side advances by one register per element, and the slot side advances by SUBVL registers per element.

In unpack mode, each source word is split into its low SUBVL bytes. Each byte is written to its own slot register, zero-extended. In pack mode, SUBVL slot bytes are gathered into one word, and any byte position above SUBVL is written as zero. A per-element predicate mask can skip elements.

The register-file side is plain and has no handshake. Reads are combinational: an address driven in a cycle returns its data in the same cycle. Writes land on the next rising edge. The register file is assumed always able to accept a read and a write, so there is no back-pressure. Flow control is the start/busy/done handshake: a start is taken only while idle, and everything it needs is latched at that moment.

Top module: `vec_pack_seq`

## Requirements
- R1: During and after reset, with no start accepted, `busy`, `done` and every `wr_en` bit are 0.
- R2: Elements are processed in ascending index order. Element i is presented (read addresses, write enables and data) in the i+1-th cycle after the edge that accepts start, so that its writes land on the i+1-th edge after that edge. `busy` is 1 from the cycle after acceptance through the `done` cycle.
- R3: Unpack (`mode`=0), element i:
  - Read port 0 addresses `wide_base`+i.
  - For each lane j < SUBVL, write port j writes register `narrow_base`+i*SUBVL+j with bits [8j+7:8j] of the read word, zero-extended to 32 bits (lane 0 is the least significant byte).
  - Ports j >= SUBVL do not write.
  - All indices wrap modulo 2^IDX_W.
- R4: Pack (`mode`=1), element i:
  - Read port j addresses `narrow_base`+i*SUBVL+j.
  - Only write port 0 writes, to `wide_base`+i.
  - Byte j of the written word is the low byte of lane j for j < SUBVL.
- R5: In pack mode, every byte position at or above SUBVL is written as zero. For SUBVL=3 this means the most significant byte is zero.
- R6: An element whose `pred` bit (bit i for element i) is 0 produces no write at all, so its destination registers keep their old values. It still uses its cycle.
- R7: `done` is a one-cycle pulse in the cycle VL+1 cycles after start is accepted. With VL=0, `done` comes in the cycle after acceptance and nothing is written.
- R8: Start is ignored while `busy` is 1, including in the `done` cycle; after `done` the block returns to idle. `mode`, `vl`, `subvl`, both bases and `pred` are sampled only at acceptance, so changing them during a run has no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a sequence; taken only when idle |
| mode | input | 1 | 0 = unpack words into byte slots, 1 = pack byte slots into words |
| vl | input | 5 | Element count 0..16; larger values act as 16 |
| subvl | input | 3 | Lanes per element 2..4; values below 2 act as 2, above 4 act as 4 |
| wide_base | input | 7 | First register of the word side |
| narrow_base | input | 7 | First register of the slot side |
| pred | input | 16 | Per-element enable mask, bit i for element i |
| busy | output | 1 | Sequence in progress (including the done cycle) |
| done | output | 1 | One-cycle completion pulse |
| rd_addr | output | 4x7 | Read address of each read port |
| rd_word | input | 32 | Full word returned by read port 0, same cycle |
| rd_lane | input | 3x8 | Low byte returned by read ports 1..3, same cycle |
| wr_en | output | 4 | Write enable of each write port |
| wr_addr | output | 4x7 | Write address of each write port |
| wr_data | output | 4x32 | Write data of each write port |

## Verification
The write-enable pattern for element i is visible in the i+1-th cycle after the accepting edge, and the data it carries is committed on the edge that follows. `done` is due VL+1 cycles after acceptance, or 1 cycle for VL=0.

The bench models the register file itself and applies writes on rising edges. It samples every output at falling edges and counts those falling edges from the accepting edge. From that count it checks the `done` cycle and sums the write enables seen over the run. It then compares the whole register file with a model that it computes element by element from the requirements.

// File: rtl/vmvp_pkg.sv
package vmvp_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_END  = 2'd2
  } seq_st_e;
endpackage

// File: rtl/vmv_seq_ctrl.sv
module vmv_seq_ctrl
  import vmvp_pkg::*;
#(
  parameter int VL_MAX = 16,
  localparam int VL_W = $clog2(VL_MAX + 1),
  localparam int ELEM_W = $clog2(VL_MAX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [VL_W-1:0]   vl_in,
  output logic              accept,
  output logic              run,
  output logic              busy,
  output logic              done,
  output logic [ELEM_W-1:0] idx
);
  seq_st_e           state_q;
  logic [ELEM_W-1:0] idx_q;
  logic [VL_W-1:0]   vl_q;
  logic [VL_W-1:0]   vl_clamped;
  logic              last_elem;

  assign vl_clamped = (vl_in > VL_W'(VL_MAX)) ? VL_W'(VL_MAX) : vl_in;
  assign last_elem  = (VL_W'(idx_q) == (vl_q - VL_W'(1)));
  assign accept     = start && (state_q == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      vl_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          vl_q    <= vl_clamped;
          idx_q   <= '0;
          state_q <= (vl_in == '0) ? ST_END : ST_RUN;
        end
        ST_RUN: begin
          if (last_elem) state_q <= ST_END;
          else           idx_q   <= idx_q + ELEM_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign run  = (state_q == ST_RUN);
  assign busy = (state_q != ST_IDLE);
  assign done = (state_q == ST_END);
  assign idx  = idx_q;

  // R2: elements step by one in ascending order while running
  assert_elem_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !last_elem) |=> (run && idx_q == $past(idx_q) + ELEM_W'(1)));

  // R7: completion is a single-cycle pulse
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: the done cycle always returns to idle, a start there is not taken
  assert_done_to_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: rtl/vmv_addr_gen.sv
module vmv_addr_gen #(
  parameter int LANES  = 4,
  parameter int IDX_W  = 7,
  parameter int ELEM_W = 4,
  parameter int SV_W   = 3
) (
  input  logic [ELEM_W-1:0]           idx,
  input  logic [SV_W-1:0]             subvl,
  input  logic [IDX_W-1:0]            wide_base,
  input  logic [IDX_W-1:0]            narrow_base,
  output logic [IDX_W-1:0]            wide_addr,
  output logic [LANES-1:0][IDX_W-1:0] narrow_addr
);
  logic [31:0]      prod;
  logic [IDX_W-1:0] group_off;

  assign prod      = 32'(idx) * 32'(subvl);
  assign group_off = prod[IDX_W-1:0];
  assign wide_addr = wide_base + IDX_W'(idx);

  for (genvar j = 0; j < LANES; j++) begin : g_lane_addr
    assign narrow_addr[j] = narrow_base + group_off + IDX_W'(j);
  end
endmodule

// File: rtl/vmv_lane_xbar.sv
module vmv_lane_xbar
  import vmvp_pkg::*;
#(
  parameter int LANES = 4,
  parameter int IDX_W = 7,
  parameter int SV_W  = 3,
  localparam int WORD_W = LANES * BYTE_W
) (
  input  logic                         pack_mode,
  input  logic                         active,
  input  logic [SV_W-1:0]              subvl,
  input  logic [IDX_W-1:0]             wide_addr,
  input  logic [LANES-1:0][IDX_W-1:0]  narrow_addr,
  input  logic [WORD_W-1:0]            rd_word,
  input  logic [LANES-1:1][BYTE_W-1:0] rd_lane,
  output logic [LANES-1:0][IDX_W-1:0]  rd_addr,
  output logic [LANES-1:0]             wr_en,
  output logic [LANES-1:0][IDX_W-1:0]  wr_addr,
  output logic [LANES-1:0][WORD_W-1:0] wr_data
);
  logic [WORD_W-1:0] packed_word;

  always_comb begin
    packed_word = '0;
    for (int j = 0; j < LANES; j++) begin
      if (SV_W'(j) < subvl) begin
        if (j == 0) packed_word[BYTE_W-1:0] = rd_word[BYTE_W-1:0];
        else        packed_word[BYTE_W*j +: BYTE_W] = rd_lane[j];
      end
    end
  end

  assign rd_addr[0] = pack_mode ? narrow_addr[0] : wide_addr;
  assign wr_en[0]   = active && (pack_mode || (subvl != '0));
  assign wr_addr[0] = pack_mode ? wide_addr : narrow_addr[0];
  assign wr_data[0] = pack_mode ? packed_word
                                : WORD_W'(rd_word[BYTE_W-1:0]);

  for (genvar j = 1; j < LANES; j++) begin : g_lane_port
    assign rd_addr[j] = narrow_addr[j];
    assign wr_en[j]   = active && !pack_mode && (SV_W'(j) < subvl);
    assign wr_addr[j] = narrow_addr[j];
    assign wr_data[j] = pack_mode ? '0 : WORD_W'(rd_word[BYTE_W*j +: BYTE_W]);
  end
endmodule

// File: rtl/vec_pack_seq.sv
module vec_pack_seq
  import vmvp_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int VL_MAX = 16,
  parameter int IDX_W  = 7,
  localparam int VL_W   = $clog2(VL_MAX + 1),
  localparam int SV_W   = $clog2(LANES + 1),
  localparam int WORD_W = LANES * BYTE_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic                         mode,
  input  logic [VL_W-1:0]              vl,
  input  logic [SV_W-1:0]              subvl,
  input  logic [IDX_W-1:0]             wide_base,
  input  logic [IDX_W-1:0]             narrow_base,
  input  logic [VL_MAX-1:0]            pred,
  output logic                         busy,
  output logic                         done,
  output logic [LANES-1:0][IDX_W-1:0]  rd_addr,
  input  logic [WORD_W-1:0]            rd_word,
  input  logic [LANES-1:1][BYTE_W-1:0] rd_lane,
  output logic [LANES-1:0]             wr_en,
  output logic [LANES-1:0][IDX_W-1:0]  wr_addr,
  output logic [LANES-1:0][WORD_W-1:0] wr_data
);
  localparam int ELEM_W = $clog2(VL_MAX);

  logic                         accept, run;
  logic [ELEM_W-1:0]            idx;
  logic                         mode_q;
  logic [SV_W-1:0]              subvl_q, subvl_clamped;
  logic [IDX_W-1:0]             wbase_q, nbase_q;
  logic [VL_MAX-1:0]            pred_q;
  logic [IDX_W-1:0]             wide_addr;
  logic [LANES-1:0][IDX_W-1:0]  narrow_addr;
  logic                         active;

  assign subvl_clamped = (subvl < SV_W'(2))     ? SV_W'(2) :
                         (subvl > SV_W'(LANES)) ? SV_W'(LANES) : subvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      subvl_q <= SV_W'(2);
      wbase_q <= '0;
      nbase_q <= '0;
      pred_q  <= '0;
    end else if (accept) begin
      mode_q  <= mode;
      subvl_q <= subvl_clamped;
      wbase_q <= wide_base;
      nbase_q <= narrow_base;
      pred_q  <= pred;
    end
  end

  vmv_seq_ctrl #(.VL_MAX(VL_MAX)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .vl_in(vl),
    .accept(accept), .run(run), .busy(busy), .done(done), .idx(idx)
  );

  vmv_addr_gen #(.LANES(LANES), .IDX_W(IDX_W), .ELEM_W(ELEM_W), .SV_W(SV_W)) u_addr (
    .idx(idx), .subvl(subvl_q), .wide_base(wbase_q), .narrow_base(nbase_q),
    .wide_addr(wide_addr), .narrow_addr(narrow_addr)
  );

  assign active = run && pred_q[idx];

  vmv_lane_xbar #(.LANES(LANES), .IDX_W(IDX_W), .SV_W(SV_W)) u_xbar (
    .pack_mode(mode_q), .active(active), .subvl(subvl_q),
    .wide_addr(wide_addr), .narrow_addr(narrow_addr),
    .rd_word(rd_word), .rd_lane(rd_lane),
    .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  // R1: no write outside a running sequence
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (wr_en == '0));

  // R3: never more write ports than lanes per element
  assert_lane_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wr_en) <= int'(subvl_q));

  // R5: unused top byte of a packed word is zero
  assert_pack_top_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && wr_en[0] && subvl_q < SV_W'(LANES)) |->
      (wr_data[0][WORD_W-1 -: BYTE_W] == '0));

  // R6: a masked element issues no write
  assert_pred_skip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !pred_q[idx]) |-> (wr_en == '0));
endmodule

// File: tb/test_vec_pack_seq.sv
`timescale 1ns/1ps
module test_vec_pack_seq;
  localparam int NREG = 128;

  typedef struct packed {
    logic       mode;
    logic [4:0] vl;
    logic [2:0] s;
    logic [6:0] wb;
    logic [6:0] nb;
    logic [15:0] pred;
  } vec_t;

  localparam vec_t VECS [0:6] = '{
    '{1'b0, 5'd4,  3'd4, 7'd0,   7'd32, 16'hFFFF},
    '{1'b0, 5'd5,  3'd3, 7'd8,   7'd64, 16'h0015},
    '{1'b1, 5'd4,  3'd4, 7'd100, 7'd16, 16'hFFFF},
    '{1'b1, 5'd6,  3'd3, 7'd110, 7'd40, 16'h003F},
    '{1'b1, 5'd16, 3'd2, 7'd0,   7'd80, 16'hA5F0},
    '{1'b0, 5'd16, 3'd2, 7'd112, 7'd0,  16'hFFFF},
    '{1'b0, 5'd3,  3'd4, 7'd20,  7'd124, 16'h0007}
  };

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mode = 1'b0;
  logic [4:0] vl = '0;
  logic [2:0] subvl = 3'd4;
  logic [6:0] wide_base = '0, narrow_base = '0;
  logic [15:0] pred = '0;
  logic busy, done;
  logic [3:0][6:0] rd_addr;
  logic [31:0] rd_word;
  logic [3:1][7:0] rd_lane;
  logic [3:0] wr_en;
  logic [3:0][6:0] wr_addr;
  logic [3:0][31:0] wr_data;

  logic [31:0] regs [NREG];
  logic [31:0] expv [NREG];
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  vec_pack_seq i_vec_pack_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .vl(vl), .subvl(subvl),
    .wide_base(wide_base), .narrow_base(narrow_base), .pred(pred),
    .busy(busy), .done(done), .rd_addr(rd_addr), .rd_word(rd_word), .rd_lane(rd_lane),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always_comb begin
    rd_word = regs[rd_addr[0]];
    for (int j = 1; j < 4; j++) rd_lane[j] = regs[rd_addr[j]][7:0];
  end

  always @(posedge clk) begin
    for (int j = 0; j < 4; j++) if (wr_en[j]) regs[wr_addr[j]] <= wr_data[j];
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expd);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expd);
    end
  endtask

  task automatic model(input vec_t v);
    logic [31:0] w;
    for (int i = 0; i < int'(v.vl); i++) begin
      if (v.pred[i]) begin
        if (!v.mode) begin
          w = expv[7'(int'(v.wb) + i)];
          for (int j = 0; j < int'(v.s); j++)
            expv[7'(int'(v.nb) + i * int'(v.s) + j)] = {24'h0, w[8*j +: 8]};
        end else begin
          w = '0;
          for (int j = 0; j < int'(v.s); j++)
            w[8*j +: 8] = expv[7'(int'(v.nb) + i * int'(v.s) + j)][7:0];
          expv[7'(int'(v.wb) + i)] = w;
        end
      end
    end
  endtask

  task automatic cmp_regs(input string req, input string what);
    int mism = 0, first = -1;
    for (int k = 0; k < NREG; k++)
      if (regs[k] !== expv[k]) begin mism++; if (first < 0) first = k; end
    if (first < 0) chk(1'b1, req, what, 0, 0);
    else chk(1'b0, req, {what, " reg"}, longint'(regs[first]), longint'(expv[first]));
  endtask

  task automatic run_case(input vec_t v, input bit disturb,
                          output int ncyc, output int nwr);
    for (int k = 0; k < NREG; k++) expv[k] = regs[k];
    model(v);
    mode = v.mode; vl = v.vl; subvl = v.s;
    wide_base = v.wb; narrow_base = v.nb; pred = v.pred;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    ncyc = 1; nwr = 0;
    if (disturb) begin
      mode = ~v.mode; vl = 5'd2; subvl = 3'd2;
      wide_base = v.wb + 7'd3; narrow_base = v.nb + 7'd5; pred = ~v.pred;
    end
    while (!done && ncyc < 100) begin
      nwr += $countones(wr_en);
      start = disturb && (ncyc == 3);
      @(negedge clk);
      ncyc++;
    end
    start = 1'b0;
  endtask

  initial begin
    int ncyc, nwr, ewr;
    for (int k = 0; k < NREG; k++) regs[k] = 32'h9E3779B9 * (k + 1);
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1", "busy/done in reset", {busy, done}, 0);
    chk(wr_en == '0, "R1", "wr_en in reset", wr_en, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && wr_en == '0, "R1", "idle after reset",
        {busy, done, wr_en}, 0);

    // table-driven runs: R2/R7 timing, R3/R4/R5/R6 contents and write counts
    for (int t = 0; t < 7; t++) begin
      run_case(VECS[t], 1'b0, ncyc, nwr);
      chk(ncyc == int'(VECS[t].vl) + 1, "R7", $sformatf("done cycle v%0d", t),
          ncyc, int'(VECS[t].vl) + 1);
      ewr = 0;
      for (int i = 0; i < int'(VECS[t].vl); i++)
        if (VECS[t].pred[i]) ewr += VECS[t].mode ? 1 : int'(VECS[t].s);
      chk(nwr == ewr, "R6", $sformatf("write count v%0d", t), nwr, ewr);
      cmp_regs(VECS[t].mode ? (VECS[t].s == 3'd3 ? "R5" : "R4") : "R3",
               $sformatf("register file v%0d", t));
      @(negedge clk);
    end

    // R7: VL=0 finishes in one cycle without writes
    run_case('{1'b0, 5'd0, 3'd4, 7'd0, 7'd32, 16'hFFFF}, 1'b0, ncyc, nwr);
    chk(ncyc == 1, "R7", "VL0 done cycle", ncyc, 1);
    chk(nwr == 0, "R7", "VL0 writes", nwr, 0);
    cmp_regs("R7", "VL0 register file");
    @(negedge clk);

    // R8: inputs changed and start pulsed mid-run and in the done cycle
    run_case('{1'b1, 5'd8, 3'd4, 7'd0, 7'd48, 16'h00FF}, 1'b1, ncyc, nwr);
    chk(ncyc == 9, "R8", "done cycle with disturbance", ncyc, 9);
    chk(nwr == 8, "R8", "write count with disturbance", nwr, 8);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b0 && done == 1'b0, "R8", "start in done cycle ignored",
        {busy, done}, 0);
    cmp_regs("R8", "latched operands");
    chk(busy == 1'b0, "R2", "busy cleared after done", busy, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule